// File: doc/BRIEF.md
# Paired-Compare PWM Timer Channel

A 16-bit up-counting timer channel with four compare registers that makes two PWM waveforms. Compare registers A and B drive output 0, and compare registers C and D drive output 1. The first register of each pair (A or C) and the second register (B or D) each have their own 2-bit action code. The code says what a match does to the pair's output: no change, drive low, drive high, or toggle. One register of the pair normally marks the active edge and the other the inactive edge.

A clear-select field picks one compare register whose match resets the counter, so that register sets the PWM period. A clear-select value of zero lets the counter run freely and wrap. If the two registers of a pair hold the same value, matches on that pair leave its output unchanged.

When the enable input is low, the counter stays at zero and each output shows its programmed initial level. Software programs the channel through a single-cycle write port. Writes take effect on the next cycle, with no shadow registers.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset, all four compare registers and the control word read as zero. The counter is 0 and both bits of `pwm_o` are 0.
- R2: While `en_i` is 0, the counter is held at 0. One cycle later, `pwm_o[0]` equals the initial-level bit of pair A/B and `pwm_o[1]` equals the initial-level bit of pair C/D.
- R3: While `en_i` is 1 and no clear occurs, the counter goes up by one every cycle. It wraps from 65535 to 0.
- R4: Clear-select field encoding: 0 means none, 1 means A, 2 means B, 3 means C, 4 means D, and 5 to 7 mean none. In a cycle where the counter equals the selected register, the counter is 0 in the next cycle.
- R5: Action code encoding: 0 means no change, 1 means drive low, 2 means drive high, 3 means toggle. The action is applied to the pin in the cycle after the cycle in which the counter equals the register.
- R6: Matches of A and of B act only on `pwm_o[0]`, and matches of C and of D act only on `pwm_o[1]`. Each match uses the matching register's own action code.
- R7: While both registers of a pair hold the same value, a counter match on that value leaves the pair's output unchanged.
- R8: The write address selects the target: 0 is A, 1 is B, 2 is C, 3 is D, and 4 is the control word. A written value is used for comparison from the next cycle on.
- R9: Control word bit fields: [1:0] action A, [3:2] action B, [5:4] action C, [7:6] action D, [10:8] clear select, [11] initial level of pin 0, [12] initial level of pin 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; when low, the counter is held at zero and the outputs show their initial levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select (0-3 compare A-D, 4 control) |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 2 | PWM outputs: bit 0 from pair A/B, bit 1 from pair C/D |

## Verification
The bench sweeps all sixteen action-code combinations of one pair against many duty and period values. Duty values range from zero, through equal to the period, to beyond the period, and each sweep is done once with pair A/B clearing on B and once with pair C/D clearing on D. This separates the four action codes, catches a swapped pin or a swapped pair register, and shows whether equal values are held or acted on. A free-running pass with clear select 0 passes the 16-bit wrap point, and a pass with clear select 6 confirms that unused codes never clear. An idle pass toggles the initial-level bits while the channel is disabled, to check bit positions and the no-enable state.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  localparam logic [2:0] CLR_NONE = 3'd0;
  localparam logic [2:0] CLR_A    = 3'd1;
  localparam logic [2:0] CLR_B    = 3'd2;
  localparam logic [2:0] CLR_C    = 3'd3;
  localparam logic [2:0] CLR_D    = 3'd4;

  localparam int unsigned N_CMP  = 4;
  localparam int unsigned N_PAIR = 2;

  // packed msb-first: init1 is bit 12, act_a is bits 1:0
  typedef struct packed {
    logic       init1;
    logic       init0;
    logic [2:0] clr_sel;
    act_e       act_d;
    act_e       act_c;
    act_e       act_b;
    act_e       act_a;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [W-1:0]             wr_data_i,
  output logic [N_CMP-1:0][W-1:0]  cmp_o,
  output ctrl_t                    ctrl_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(N_CMP);

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_o[g] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g))
        cmp_o[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ctrl_o <= '0;
    else if (wr_en_i && wr_addr_i == CTRL_ADDR)
      ctrl_o <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [2:0]              clr_sel_i,
  input  logic [N_CMP-1:0][W-1:0] cmp_i,
  output logic [W-1:0]            cnt_o,
  output logic [N_CMP-1:0]        hit_o
);
  logic clr;

  for (genvar g = 0; g < N_CMP; g++) begin : g_hit
    assign hit_o[g] = (cnt_o == cmp_i[g]);
  end

  always_comb begin
    unique case (clr_sel_i)
      CLR_A:   clr = hit_o[0];
      CLR_B:   clr = hit_o[1];
      CLR_C:   clr = hit_o[2];
      CLR_D:   clr = hit_o[3];
      default: clr = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_o <= '0;
    else if (!en_i || clr)
      cnt_o <= '0;
    else
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         init_i,
  input  logic [W-1:0] lead_val_i,
  input  logic [W-1:0] trail_val_i,
  input  logic         lead_hit_i,
  input  logic         trail_hit_i,
  input  act_e         lead_act_i,
  input  act_e         trail_act_i,
  output logic         pwm_o
);
  logic same;
  act_e act;
  logic nxt;

  assign same = (lead_val_i == trail_val_i);

  always_comb begin
    act = ACT_HOLD;
    if (!same) begin
      if (lead_hit_i)       act = lead_act_i;
      else if (trail_hit_i) act = trail_act_i;
    end
    unique case (act)
      ACT_LOW:    nxt = 1'b0;
      ACT_HIGH:   nxt = 1'b1;
      ACT_TOGGLE: nxt = ~pwm_o;
      default:    nxt = pwm_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pwm_o <= 1'b0;
    else if (!en_i)
      pwm_o <= init_i;
    else
      pwm_o <= nxt;
  end
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [N_PAIR-1:0] pwm_o
);
  logic [N_CMP-1:0][W-1:0] cmp_q;
  ctrl_t                   ctrl_q;
  logic [W-1:0]            cnt_q;
  logic [N_CMP-1:0]        hit;
  act_e [N_CMP-1:0]        act;
  logic [N_PAIR-1:0]       init;

  assign act  = {ctrl_q.act_d, ctrl_q.act_c, ctrl_q.act_b, ctrl_q.act_a};
  assign init = {ctrl_q.init1, ctrl_q.init0};

  pwm_regfile #(.W(W), .AW(AW)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cmp_o     (cmp_q),
    .ctrl_o    (ctrl_q)
  );

  pwm_counter #(.W(W)) cnt_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .clr_sel_i (ctrl_q.clr_sel),
    .cmp_i     (cmp_q),
    .cnt_o     (cnt_q),
    .hit_o     (hit)
  );

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    pwm_pair_out #(.W(W)) out_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_i),
      .init_i      (init[p]),
      .lead_val_i  (cmp_q[2*p]),
      .trail_val_i (cmp_q[2*p+1]),
      .lead_hit_i  (hit[2*p]),
      .trail_hit_i (hit[2*p+1]),
      .lead_act_i  (act[2*p]),
      .trail_act_i (act[2*p+1]),
      .pwm_o       (pwm_o[p])
    );
  end
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk
  import pwm_pair_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [W-1:0]            cnt_q,
  input logic [N_CMP-1:0][W-1:0] cmp_q,
  input ctrl_t                   ctrl_q,
  input logic [N_PAIR-1:0]       pwm_o
);
  p_idle_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && (pwm_o == {$past(ctrl_q.init1), $past(ctrl_q.init0)}));

  p_count_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ctrl_q.clr_sel == CLR_NONE |=> cnt_q == W'($past(cnt_q) + 1'b1));

  p_clear_on_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ctrl_q.clr_sel == CLR_B && cnt_q == cmp_q[1] |=> cnt_q == '0);

  p_clear_on_d_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ctrl_q.clr_sel == CLR_D && cnt_q == cmp_q[3] |=> cnt_q == '0);

  p_lead_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cmp_q[0] != cmp_q[1] && cnt_q == cmp_q[0] && ctrl_q.act_a == ACT_HIGH
    |=> pwm_o[0]);

  p_trail_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cmp_q[2] != cmp_q[3] && cnt_q == cmp_q[3] && ctrl_q.act_d == ACT_LOW
    |=> !pwm_o[1]);

  p_equal_hold0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cmp_q[0] == cmp_q[1] && cnt_q == cmp_q[0] |=> $stable(pwm_o[0]));

  p_equal_hold1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cmp_q[2] == cmp_q[3] && cnt_q == cmp_q[2] |=> $stable(pwm_o[1]));
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.W(W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .cnt_q  (cnt_q),
  .cmp_q  (cmp_q),
  .ctrl_q (ctrl_q),
  .pwm_o  (pwm_o)
);

// File: tb/pwm_pair_timer_tb_top.sv
module pwm_pair_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   pwm;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference state, built from the requirements
  logic [W-1:0] m_reg [4];
  logic [12:0]  m_ctrl;
  logic [W-1:0] m_cnt;
  logic [1:0]   m_out;

  always #2 clk = ~clk;

  pwm_pair_timer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .pwm_o     (pwm)
  );

  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      m_ctrl = '0;
      m_cnt  = '0;
      m_out  = '0;
    end else begin
      logic [1:0]   nout;
      logic [W-1:0] ncnt;
      logic [2:0]   sel;
      nout = m_out;
      sel  = m_ctrl[10:8];
      if (!en) begin
        nout = m_ctrl[12:11];
        ncnt = '0;
      end else begin
        for (int p = 0; p < 2; p++) begin
          if (m_reg[2*p] != m_reg[2*p+1]) begin
            if (m_cnt == m_reg[2*p])
              nout[p] = apply_act(m_ctrl[4*p +: 2], m_out[p]);
            else if (m_cnt == m_reg[2*p+1])
              nout[p] = apply_act(m_ctrl[4*p+2 +: 2], m_out[p]);
          end
        end
        if (sel >= 3'd1 && sel <= 3'd4 && m_cnt == m_reg[sel-3'd1])
          ncnt = '0;
        else
          ncnt = m_cnt + 1'b1;
      end
      if (wr_en) begin
        if (wr_addr < 3'd4) m_reg[wr_addr[1:0]] = wr_data;
        else if (wr_addr == 3'd4) m_ctrl = wr_data[12:0];
      end
      m_out = nout;
      m_cnt = ncnt;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (pwm !== m_out) begin
        n_fail++;
        $display("FAIL %s: pwm_o=%b expected %b (t=%0t)", cur_req, pwm, m_out, $time);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic [W-1:0] ctrl_word(input logic [1:0] aa, ab, ac, ad,
                                             input logic [2:0] sel,
                                             input logic i0, i1);
    return W'({i1, i0, sel, ad, ac, ab, aa});
  endfunction

  task automatic run_case(input logic [W-1:0] a, b, c, d, ctl, input int ncyc);
    en = 1'b0;
    wr(3'd0, a);
    wr(3'd1, b);
    wr(3'd2, c);
    wr(3'd3, d);
    wr(3'd4, ctl);
    @(negedge clk);
    en = 1'b1;
    repeat (ncyc) @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (pwm !== 2'b00) begin
      n_fail++;
      $display("FAIL R1: pwm_o=%b expected 00", pwm);
    end
    chk_on = 1'b1;

    // R2 / R9: initial levels while disabled
    cur_req = "R2 R9";
    for (int i = 0; i < 4; i++) begin
      wr(3'd4, ctrl_word(2'd0, 2'd0, 2'd0, 2'd0, 3'd0, i[0], i[1]));
      repeat (3) @(negedge clk);
    end

    // R5 R6 R7 R4: pair A/B swept, period on B
    cur_req = "R5 R6 R7 R4 R8";
    for (int aa = 0; aa < 4; aa++)
      for (int ab = 0; ab < 4; ab++)
        for (int bv = 2; bv < 6; bv++)
          for (int av = 0; av < 7; av++)
            run_case(W'(av), W'(bv), W'(bv - 1), W'(1),
                     ctrl_word(aa[1:0], ab[1:0], 2'd3, 2'd1, 3'd2, av[0], ~av[0]),
                     3 * (bv + 1) + 2);

    // pair C/D swept, period on D
    cur_req = "R5 R6 R7 R4 R9";
    for (int ac = 0; ac < 4; ac++)
      for (int ad = 0; ad < 4; ad++)
        for (int dv = 2; dv < 6; dv++)
          for (int cv = 0; cv < 7; cv++)
            run_case(W'(1), W'(dv - 1), W'(cv), W'(dv),
                     ctrl_word(2'd2, 2'd1, ac[1:0], ad[1:0], 3'd4, ~cv[0], cv[0]),
                     3 * (dv + 1) + 2);

    // clear on A and on C
    cur_req = "R4 R5";
    run_case(W'(4), W'(2), W'(1), W'(3),
             ctrl_word(2'd3, 2'd2, 2'd2, 2'd1, 3'd1, 1'b0, 1'b0), 20);
    run_case(W'(2), W'(5), W'(6), W'(3),
             ctrl_word(2'd3, 2'd1, 2'd1, 2'd2, 3'd3, 1'b1, 1'b1), 24);

    // unused clear code: no clear
    cur_req = "R4 R3";
    run_case(W'(10), W'(30), W'(20), W'(20),
             ctrl_word(2'd3, 2'd3, 2'd3, 2'd3, 3'd6, 1'b0, 1'b1), 200);

    // R8: write while running takes effect next cycle
    cur_req = "R8 R5";
    run_case(W'(3), W'(8), W'(2), W'(7),
             ctrl_word(2'd2, 2'd1, 2'd2, 2'd1, 3'd2, 1'b0, 1'b0), 10);
    en = 1'b1;
    wr(3'd0, W'(5));
    wr(3'd3, W'(4));
    repeat (30) @(negedge clk);
    en = 1'b0;

    // R3: free run across the 16-bit wrap
    cur_req = "R3";
    run_case(W'(5), W'(40000), W'(65535), W'(0),
             ctrl_word(2'd3, 2'd3, 2'd3, 2'd2, 3'd0, 1'b0, 1'b0), 65560);
    @(negedge clk);

    done = 1'b1;
    chk_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule